// File: doc/BRIEF.md
# Inverter Gate-Drive Fault and Undervoltage Controller

This block sits between a PWM generator and the six gate drivers of a three-phase bridge. Every clock it samples six PWM requests, a short-circuit comparator that has already been synchronised, one undervoltage flag for the low-side supply and one undervoltage flag per high-side supply. It then registers six gate commands and an active-low fault line. A short circuit must be seen on several consecutive samples before it acts. It then shuts every gate and holds the fault line low for a number of cycles taken from a 16-bit length input. Undervoltage on a high-side supply only masks that phase's upper gate, raises no fault, and releases as soon as the supply is good again. Undervoltage on the low-side supply shuts all gates and raises the fault. After that supply recovers, a gate comes back only on a fresh rising edge of its own request.

A single state machine holds the protection state. Its states are `ST_UVLO` (low-side supply low, the state after reset), `ST_RUN` (gates follow armed requests) and `ST_SC_FAULT` (fault timer running). Its transitions are: uv-enter (any state to `ST_UVLO` when the low-side flag is sampled high), uv-clear (`ST_UVLO` to `ST_RUN` when the flag is sampled low), sc-trip (`ST_RUN` to `ST_SC_FAULT` when the filter completes) and sc-expire (`ST_SC_FAULT` to `ST_RUN` when the timer runs out). A rising request edge arms a gate only while the machine stays in `ST_RUN`. Every transition into or out of `ST_RUN` disarms all six gates.

Top module: `gate_fault_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, all six gate outputs are 0 and `fault_n` is 0 (the machine starts in `ST_UVLO`).
- R2: In `ST_UVLO`, a clock edge that samples `ls_uv` = 0 sets `fault_n` to 1 after that edge, and the gates stay 0 on that edge.
- R3: In `ST_RUN`, a gate turns on one cycle after a sample where its request is 1 and the previous sample was 0. From then on it follows its request with one cycle of delay. A request that is already high when running starts keeps its gate at 0.
- R4: `SC_FILT` consecutive samples of `sc_sense` = 1 in `ST_RUN` drive all gates to 0 and `fault_n` to 0 after the last of them. A single 0 sample restarts the count, so fewer than `SC_FILT` samples cause no trip.
- R5: After a trip, `fault_n` stays low for exactly `fault_len` cycles, where `fault_len` is sampled on the trip edge and a value of 0 counts as 1.
- R6: While the fault pulse is active, gate outputs stay 0 whatever the requests, and `sc_sense` neither extends nor restarts the pulse.
- R7: When the fault pulse ends, every gate stays 0 until it sees a fresh rising edge of its request.
- R8: Bit p of `pwm_in` (p = 0,1,2 for phases U,V,W) is the high-side request of phase p, and bit p+3 is its low-side request. A sample with `hs_uv[p]` = 1 forces gate p to 0 after that edge, without affecting other gates or `fault_n`. When `hs_uv[p]` returns to 0, gate p follows its request again on the next edge with no new edge needed.
- R9: In any state, a sample with `ls_uv` = 1 drives all gates and `fault_n` to 0 after that edge. This takes priority over a trip or a running fault timer, and recovery then follows R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 6 | Gate requests: [2:0] high side U,V,W; [5:3] low side U,V,W |
| sc_sense | input | 1 | Synchronised short-circuit comparator, 1 = above reference |
| ls_uv | input | 1 | Low-side supply undervoltage, 1 = under |
| hs_uv | input | 3 | High-side supply undervoltage per phase U,V,W |
| fault_len | input | 16 | Fault pulse length in cycles, taken at trip |
| gate_out | output | 6 | Registered gate commands, same bit order as pwm_in |
| fault_n | output | 1 | Active-low fault line |

## Verification
Every result is registered once, so a gate follows its armed request, an undervoltage flag or a completed short-circuit count on the edge that samples that input. The bench changes inputs one time unit after a rising edge and reads the outputs one edge later, just before it drives again. The short-circuit trip shows up after the `SC_FILT`-th consecutive high sample. The fault line then stays low for exactly `fault_len` samples, and the bench measures this by counting low samples edge by edge. A high-side flag clearing and a low-side flag clearing are told apart by whether the gate returns on the very next edge or only after a new request edge.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

    typedef enum logic [1:0] {
        ST_UVLO     = 2'd0,
        ST_RUN      = 2'd1,
        ST_SC_FAULT = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/gfc_sc_filter.sv
// Counts consecutive high samples of the short-circuit comparator.
module gfc_sc_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sense,
    output logic trip
);
    localparam int CW = (FILT > 1) ? $clog2(FILT + 1) : 1;
    localparam logic [CW-1:0] LIM = CW'(FILT - 1);

    logic [CW-1:0] cnt_q;
    logic          at_lim;

    always_comb begin
        at_lim = (cnt_q == LIM);
        trip   = en & sense & at_lim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en && sense) begin
            cnt_q <= at_lim ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/gfc_fault_timer.sv
// Down-counter that sets the length of the fault pulse.
module gfc_fault_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_comb begin
        expired = (cnt_q <= W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (!expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/gfc_gate_arm.sv
// One arming flag per gate: set on a rising request edge, cleared on any state change.
module gfc_gate_arm #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         keep,
    input  logic [N-1:0] req,
    output logic [N-1:0] arm_nx
);
    logic [N-1:0] req_q;
    logic [N-1:0] armed_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic rise;
        always_comb begin
            rise      = req[g] & ~req_q[g];
            arm_nx[g] = keep & (armed_q[g] | rise);
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[g]   <= 1'b1;
                armed_q[g] <= 1'b0;
            end else begin
                req_q[g]   <= req[g];
                armed_q[g] <= arm_nx[g];
            end
        end
    end
endmodule

// File: rtl/gate_fault_ctrl.sv
module gate_fault_ctrl
    import gfc_pkg::*;
#(
    parameter int PHASES  = 3,
    parameter int SC_FILT = 4,
    parameter int LEN_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*PHASES-1:0]   pwm_in,
    input  logic                  sc_sense,
    input  logic                  ls_uv,
    input  logic [PHASES-1:0]     hs_uv,
    input  logic [LEN_W-1:0]      fault_len,
    output logic [2*PHASES-1:0]   gate_out,
    output logic                  fault_n
);
    localparam int NG = 2 * PHASES;

    ctl_state_e    state_q, state_nx;
    logic          sc_trip, tmr_expired, tmr_load, arm_keep;
    logic [NG-1:0] arm_nx, hs_ok, gate_nx;

    gfc_sc_filter #(.FILT(SC_FILT)) i_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_RUN),
        .sense (sc_sense),
        .trip  (sc_trip)
    );

    gfc_fault_timer #(.W(LEN_W)) i_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (fault_len),
        .expired (tmr_expired)
    );

    gfc_gate_arm #(.N(NG)) i_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .keep   (arm_keep),
        .req    (pwm_in),
        .arm_nx (arm_nx)
    );

    // High-side gates are masked by their own supply flag; low-side gates never are.
    for (genvar p = 0; p < PHASES; p++) begin : g_hs
        assign hs_ok[p]          = ~hs_uv[p];
        assign hs_ok[p + PHASES] = 1'b1;
    end

    // Next-state logic: uv-enter has priority over sc-trip and sc-expire.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_UVLO:     state_nx = ls_uv ? ST_UVLO : ST_RUN;
            ST_RUN: begin
                if (ls_uv)        state_nx = ST_UVLO;
                else if (sc_trip) state_nx = ST_SC_FAULT;
                else              state_nx = ST_RUN;
            end
            ST_SC_FAULT: begin
                if (ls_uv)            state_nx = ST_UVLO;
                else if (tmr_expired) state_nx = ST_RUN;
                else                  state_nx = ST_SC_FAULT;
            end
            default:     state_nx = ST_UVLO;
        endcase
        tmr_load = (state_q == ST_RUN) && (state_nx == ST_SC_FAULT);
        arm_keep = (state_q == ST_RUN) && (state_nx == ST_RUN);
        gate_nx  = (state_nx == ST_RUN) ? (arm_nx & pwm_in & hs_ok) : '0;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UVLO;
        else        state_q <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_out <= '0;
            fault_n  <= 1'b0;
        end else begin
            gate_out <= gate_nx;
            fault_n  <= (state_nx == ST_RUN);
        end
    end
endmodule

// File: rtl/gfc_checker.sv
module gfc_checker #(
    parameter int PHASES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*PHASES-1:0] pwm_in,
    input logic                sc_sense,
    input logic                ls_uv,
    input logic [PHASES-1:0]   hs_uv,
    input logic [2*PHASES-1:0] gate_out,
    input logic                fault_n
);
    AST_LSUV_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        ls_uv |=> (gate_out == '0) && !fault_n); // R9

    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_out == '0)); // R6

    AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out & ~$past(pwm_in)) == '0); // R3

    AST_HS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_uv != '0) |=> ((gate_out[PHASES-1:0] & $past(hs_uv)) == '0)); // R8

    AST_RELEASE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> (gate_out == '0)); // R7

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> ($past(ls_uv) || $past(sc_sense))); // R4
endmodule

bind gate_fault_ctrl gfc_checker #(.PHASES(PHASES)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_in   (pwm_in),
    .sc_sense (sc_sense),
    .ls_uv    (ls_uv),
    .hs_uv    (hs_uv),
    .gate_out (gate_out),
    .fault_n  (fault_n)
);

// File: tb/test_gate_fault_ctrl.sv
module test_gate_fault_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pwm_in = '0;
    logic        sc_sense = 1'b0;
    logic        ls_uv = 1'b0;
    logic [2:0]  hs_uv = '0;
    logic [15:0] fault_len = 16'd3;
    logic [5:0]  gate_out;
    logic        fault_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    gate_fault_ctrl i_gate_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .sc_sense(sc_sense),
        .ls_uv(ls_uv), .hs_uv(hs_uv), .fault_len(fault_len),
        .gate_out(gate_out), .fault_n(fault_n)
    );

    // Vector: [22] ls_uv, [21:19] hs_uv, [18] sc_sense, [17:12] pwm_in,
    //         [11:6] expected gates, [5] expected fault_n, [4:0] requirement number
    localparam int NV = 29;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 3'b000, 1'b0, 6'h00, 6'h00, 1'b0, 5'd9},  // R9 low-side UV
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h00, 1'b1, 5'd2},  // R2 clear, request already high
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h00, 1'b1, 5'd3},  // R3 no edge, stays off
        {1'b0, 3'b000, 1'b0, 6'h00, 6'h00, 1'b1, 5'd3},  // R3
        {1'b0, 3'b000, 1'b0, 6'h09, 6'h09, 1'b1, 5'd3},  // R3 edge arms U
        {1'b0, 3'b000, 1'b0, 6'h00, 6'h00, 1'b1, 5'd3},  // R3 follows
        {1'b0, 3'b000, 1'b0, 6'h09, 6'h09, 1'b1, 5'd3},  // R3 armed follows
        {1'b0, 3'b000, 1'b0, 6'h12, 6'h12, 1'b1, 5'd3},  // R3 V edge
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h3F, 1'b1, 5'd3},  // R3 all on
        {1'b0, 3'b001, 1'b0, 6'h3F, 6'h3E, 1'b1, 5'd8},  // R8 U high side masked
        {1'b0, 3'b111, 1'b0, 6'h3F, 6'h38, 1'b1, 5'd8},  // R8 all high sides masked
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h3F, 1'b1, 5'd8},  // R8 immediate recovery
        {1'b0, 3'b000, 1'b1, 6'h3F, 6'h3F, 1'b1, 5'd4},  // R4 count 1
        {1'b0, 3'b000, 1'b1, 6'h3F, 6'h3F, 1'b1, 5'd4},  // R4 count 2
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h3F, 1'b1, 5'd4},  // R4 restart
        {1'b0, 3'b000, 1'b1, 6'h3F, 6'h3F, 1'b1, 5'd4},  // R4
        {1'b0, 3'b000, 1'b1, 6'h3F, 6'h3F, 1'b1, 5'd4},  // R4
        {1'b0, 3'b000, 1'b1, 6'h3F, 6'h3F, 1'b1, 5'd4},  // R4 three samples only
        {1'b0, 3'b000, 1'b1, 6'h3F, 6'h00, 1'b0, 5'd4},  // R4 fourth sample trips
        {1'b0, 3'b000, 1'b0, 6'h00, 6'h00, 1'b0, 5'd6},  // R6 fault cycle 2
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h00, 1'b0, 5'd6},  // R6 edge ignored, cycle 3
        {1'b0, 3'b000, 1'b0, 6'h3F, 6'h00, 1'b1, 5'd7},  // R7 released but disarmed
        {1'b0, 3'b000, 1'b0, 6'h00, 6'h00, 1'b1, 5'd7},  // R7
        {1'b0, 3'b000, 1'b0, 6'h01, 6'h01, 1'b1, 5'd7},  // R7 fresh edge
        {1'b1, 3'b000, 1'b0, 6'h01, 6'h00, 1'b0, 5'd9},  // R9
        {1'b1, 3'b000, 1'b1, 6'h01, 6'h00, 1'b0, 5'd9},  // R9 sc ignored in UV
        {1'b0, 3'b000, 1'b0, 6'h01, 6'h00, 1'b1, 5'd9},  // R9 recovery needs edge
        {1'b0, 3'b000, 1'b0, 6'h00, 6'h00, 1'b1, 5'd9},  // R9
        {1'b0, 3'b000, 1'b0, 6'h20, 6'h20, 1'b1, 5'd9}   // R9 fresh edge W low
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [5:0] eg, input logic ef);
        n_chk++;
        if (gate_out !== eg || fault_n !== ef) begin
            n_fail++;
            $display("FAIL %s: gate_out=%h fault_n=%b expected gate_out=%h fault_n=%b",
                     req, gate_out, fault_n, eg, ef);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: value=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Trips from ST_RUN with sc held for four samples; returns the measured low length.
    task automatic trip_and_measure(input logic [15:0] len, input bit hold_sc, output int low);
        fault_len = len;
        sc_sense  = 1'b1;
        repeat (4) tick();
        check("R4", 6'h00, 1'b0);
        if (!hold_sc) sc_sense = 1'b0;
        low = 0;
        while (!fault_n && low < 1000) begin
            low++;
            tick();
        end
        sc_sense = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin : main
        int low;
        // R1: reset state
        #1;
        check("R1", 6'h00, 1'b0);
        repeat (3) tick();
        check("R1", 6'h00, 1'b0);
        ls_uv = 1'b1;
        rst_n = 1'b1;
        tick();
        check("R1", 6'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            ls_uv    = VEC[i][22];
            hs_uv    = VEC[i][21:19];
            sc_sense = VEC[i][18];
            pwm_in   = VEC[i][17:12];
            tick();
            check($sformatf("R%0d vec%0d", VEC[i][4:0], i), VEC[i][11:6], VEC[i][5]);
        end

        // R5: duration of 10 cycles, sc released after the trip
        trip_and_measure(16'd10, 1'b0, low);
        check_int("R5 len10", low, 10);
        // R5: zero acts as one
        trip_and_measure(16'd0, 1'b0, low);
        check_int("R5 len0", low, 1);
        // R6: sc held high during the pulse neither extends nor restarts it
        trip_and_measure(16'd6, 1'b1, low);
        check_int("R6 held sc", low, 6);
        tick();
        tick();
        check("R6 no retrigger", 6'h00, 1'b1);
        // R5: fault_len changes during the pulse have no effect
        fault_len = 16'd5;
        sc_sense  = 1'b1;
        repeat (4) tick();
        sc_sense  = 1'b0;
        fault_len = 16'd50;
        low = 0;
        while (!fault_n && low < 1000) begin
            low++;
            tick();
        end
        check_int("R5 latched", low, 5);

        // R9: low-side UV overrides a running fault timer
        fault_len = 16'd40;
        sc_sense  = 1'b1;
        repeat (4) tick();
        sc_sense  = 1'b0;
        tick();
        ls_uv = 1'b1;
        tick();
        check("R9 during fault", 6'h00, 1'b0);
        ls_uv = 1'b0;
        tick();
        check("R9 timer abandoned", 6'h00, 1'b1);

        // R8: high-side flag does not affect low-side gates or the fault line
        pwm_in = 6'h00;
        tick();
        pwm_in = 6'h24;
        tick();
        check("R8 armed W", 6'h24, 1'b1);
        hs_uv = 3'b100;
        tick();
        check("R8 W masked", 6'h20, 1'b1);
        hs_uv = 3'b000;
        tick();
        check("R8 W back", 6'h24, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule